// File: doc/BRIEF.md
# Bit-sliced ALU with signed set-less-than

This block is a purely combinational arithmetic and logic unit built as a ripple chain of one-bit slices. Every slice receives the same two low operation-code bits and the same negate line. Each slice holds a full adder, an AND gate, an OR gate and a four-way selector. The chain computes bitwise AND, bitwise OR, two's-complement addition, subtraction and a signed less-than comparison on two operands. It also reports a zero flag and a signed overflow flag.

Subtraction comes from one negate line, the top control bit. It inverts the B operand in every slice and also supplies the carry into bit 0. The most significant slice is a distinct variant. It compares the carry entering it with the carry leaving it to detect overflow. It forms a comparison bit from the difference's sign corrected by that overflow, and feeds this bit back to the "less" input of bit 0. All other slices receive a constant 0 on "less". A small decoder maps the control code onto the slice controls. It enables the result only for defined codes and gates the overflow flag so that it is reported only for arithmetic operations.

Top module: `slice_alu`

## Requirements
- R1: Code 3'b000 gives result = A AND B, bit by bit.
- R2: Code 3'b001 gives result = A OR B, bit by bit.
- R3: Code 3'b010 gives result = (A + B) modulo 2^32.
- R4: Code 3'b110 gives result = (A - B) modulo 2^32, formed as A + ~B + 1.
- R5: Code 3'b111 gives result = 1 when A is less than B as signed two's-complement numbers, otherwise 0. This holds also when A - B overflows. For example, A = 0x80000000 and B = 1 gives 1.
- R6: The overflow flag is 1 for code 3'b010 or 3'b110 exactly when the signed result cannot be represented in 32 bits. It is 0 for every other code.
- R7: The zero flag is 1 exactly when all 32 result bits are 0, for every code.
- R8: The undefined codes 3'b011, 3'b100 and 3'b101 give a result of 0. As a consequence the zero flag is 1 and the overflow flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| op_i | input | 3 | Operation code; bit 2 is the negate line |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The checker evaluates its immediate properties only while every operand and code bit is a known 0 or 1. It takes the outputs to be settled ripple values for the inputs presented at that moment. The bench changes inputs only on the falling clock edge and compares at the following rising edge, so the chain has half a period to settle before any comparison. The stimulus uses defined and undefined codes with the operands 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF in every pairing, which covers all sign combinations for the comparison. It then adds random operands.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    // slice selector values (low two code bits)
    localparam logic [1:0] SEL_AND  = 2'b00;
    localparam logic [1:0] SEL_OR   = 2'b01;
    localparam logic [1:0] SEL_SUM  = 2'b10;
    localparam logic [1:0] SEL_LESS = 2'b11;

endpackage

// File: rtl/slice_alu_dec.sv
module slice_alu_dec
    import slice_alu_pkg::*;
(
    input  logic [2:0] op_i,
    output logic       negate_o,
    output logic [1:0] sel_o,
    output logic       en_o,
    output logic       arith_o
);

    always_comb begin
        negate_o = op_i[2];
        sel_o    = op_i[1:0];
        en_o     = 1'b0;
        arith_o  = 1'b0;
        unique case (op_i)
            OP_AND: en_o = 1'b1;
            OP_OR:  en_o = 1'b1;
            OP_ADD: begin
                en_o    = 1'b1;
                arith_o = 1'b1;
            end
            OP_SUB: begin
                en_o    = 1'b1;
                arith_o = 1'b1;
            end
            OP_SLT: en_o = 1'b1;
            default: begin
                en_o    = 1'b0;
                arith_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/slice_alu_bit.sv
module slice_alu_bit
    import slice_alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       cin_i,
    input  logic       less_i,
    input  logic       negate_i,
    input  logic [1:0] sel_i,
    input  logic       en_i,
    output logic       res_o,
    output logic       cout_o
);

    logic b_eff;
    logic sum;

    assign b_eff  = b_i ^ negate_i;
    assign sum    = a_i ^ b_eff ^ cin_i;
    assign cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);

    always_comb begin
        res_o = 1'b0;
        if (en_i) begin
            unique case (sel_i)
                SEL_AND:  res_o = a_i & b_eff;
                SEL_OR:   res_o = a_i | b_eff;
                SEL_SUM:  res_o = sum;
                SEL_LESS: res_o = less_i;
                default:  res_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/slice_alu_msb.sv
module slice_alu_msb
    import slice_alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       cin_i,
    input  logic       negate_i,
    input  logic [1:0] sel_i,
    input  logic       en_i,
    output logic       res_o,
    output logic       set_o,
    output logic       ovf_o
);

    logic b_eff;
    logic sum;
    logic cout;

    assign b_eff = b_i ^ negate_i;
    assign sum   = a_i ^ b_eff ^ cin_i;
    assign cout  = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);

    // carry entering versus carry leaving the top bit
    assign ovf_o = cin_i ^ cout;
    // sign of the difference, corrected when it wrapped
    assign set_o = sum ^ ovf_o;

    always_comb begin
        res_o = 1'b0;
        if (en_i) begin
            unique case (sel_i)
                SEL_AND:  res_o = a_i & b_eff;
                SEL_OR:   res_o = a_i | b_eff;
                SEL_SUM:  res_o = sum;
                SEL_LESS: res_o = 1'b0;
                default:  res_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/slice_alu_zero.sv
module slice_alu_zero #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res_i,
    output logic             zero_o
);

    assign zero_o = ~(|res_i);

endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import slice_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic           negate;
    logic [1:0]     sel;
    logic           en;
    logic           arith;
    logic [MSB:0]   carry;
    logic           set_w;
    logic           ovf_raw;

    slice_alu_dec u_dec (
        .op_i     (op_i),
        .negate_o (negate),
        .sel_o    (sel),
        .en_o     (en),
        .arith_o  (arith)
    );

    assign carry[0] = negate;

    for (genvar i = 0; i < MSB; i++) begin : g_slice
        logic less_w;
        if (i == 0) begin : g_lsb
            assign less_w = set_w;
        end else begin : g_mid
            assign less_w = 1'b0;
        end

        slice_alu_bit u_bit (
            .a_i      (a_i[i]),
            .b_i      (b_i[i]),
            .cin_i    (carry[i]),
            .less_i   (less_w),
            .negate_i (negate),
            .sel_i    (sel),
            .en_i     (en),
            .res_o    (result_o[i]),
            .cout_o   (carry[i+1])
        );
    end

    slice_alu_msb u_msb (
        .a_i      (a_i[MSB]),
        .b_i      (b_i[MSB]),
        .cin_i    (carry[MSB]),
        .negate_i (negate),
        .sel_i    (sel),
        .en_i     (en),
        .res_o    (result_o[MSB]),
        .set_o    (set_w),
        .ovf_o    (ovf_raw)
    );

    assign ovf_o = arith & ovf_raw;

    slice_alu_zero #(.WIDTH(WIDTH)) u_zero (
        .res_i  (result_o),
        .zero_o (zero_o)
    );

endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] result_o,
    input logic             zero_o,
    input logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] s_add;
    logic [WIDTH-1:0] s_sub;
    logic             add_ov;
    logic             sub_ov;
    logic             known;

    assign s_add  = a_i + b_i;
    assign s_sub  = a_i - b_i;
    assign add_ov = (a_i[MSB] == b_i[MSB]) && (s_add[MSB] != a_i[MSB]);
    assign sub_ov = (a_i[MSB] != b_i[MSB]) && (s_sub[MSB] != a_i[MSB]);
    assign known  = !$isunknown({a_i, b_i, op_i});

    always_comb begin
        if (known) begin
            if (op_i == 3'b000) AST_AND_BITS: assert (result_o == (a_i & b_i)); // R1
            if (op_i == 3'b001) AST_OR_BITS: assert (result_o == (a_i | b_i)); // R2
            if (op_i == 3'b010) AST_ADD_SUM: assert (result_o == s_add); // R3
            if (op_i == 3'b110) AST_SUB_DIFF: assert (result_o == s_sub); // R4
            if (op_i == 3'b111) AST_SLT_SIGNED: assert (result_o == {{MSB{1'b0}}, ($signed(a_i) < $signed(b_i))}); // R5
            if (op_i == 3'b010) AST_ADD_OVERFLOW: assert (ovf_o == add_ov); // R6
            if (op_i == 3'b110) AST_SUB_OVERFLOW: assert (ovf_o == sub_ov); // R6
            if (op_i[1:0] != 2'b10) AST_NO_OVERFLOW: assert (!ovf_o); // R6
            if (op_i == 3'b110) AST_ZERO_EQUAL: assert (zero_o == (a_i == b_i)); // R7
            if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101) AST_UNUSED_CLEAR: assert (result_o == '0 && zero_o); // R8
        end
    end

endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/slice_alu_bench.sv
module slice_alu_bench;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [2:0]  op;
        logic [31:0] res;
        logic        z;
        logic        v;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [2:0]  op_i = 3'b000;
    logic [31:0] result_o;
    logic        zero_o;
    logic        ovf_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    item_t q[$];

    always #10 clk = ~clk; // 50 MHz

    slice_alu u_slice_alu (
        .a_i      (a_i),
        .b_i      (b_i),
        .op_i     (op_i),
        .result_o (result_o),
        .zero_o   (zero_o),
        .ovf_o    (ovf_o)
    );

    function automatic item_t model(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
        item_t it;
        it.a = a; it.b = b; it.op = op; it.v = 1'b0;
        case (op)
            3'b000: it.res = a & b;
            3'b001: it.res = a | b;
            3'b010: begin
                it.res = a + b;
                it.v = (a[31] == b[31]) && (it.res[31] != a[31]);
            end
            3'b110: begin
                it.res = a - b;
                it.v = (a[31] != b[31]) && (it.res[31] != a[31]);
            end
            3'b111: it.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: it.res = 32'd0;
        endcase
        it.z = (it.res == 32'd0);
        return it;
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b110: return "R4";
            3'b111: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
        @(negedge clk);
        a_i = a; b_i = b; op_i = op;
        q.push_back(model(a, b, op));
    endtask

    // monitor: compares at the rising edge after each falling-edge drive
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            if (rst_n && q.size() > 0) begin
                it = q.pop_front();
                check(tag_of(it.op), result_o, it.res);
                check("R7", {31'd0, zero_o}, {31'd0, it.z});
                check("R6", {31'd0, ovf_o}, {31'd0, it.v});
            end
        end
    end

    initial begin
        logic [31:0] corner [4];
        logic [2:0]  ops [8];
        corner[0] = 32'h0000_0000; corner[1] = 32'h7FFF_FFFF;
        corner[2] = 32'h8000_0000; corner[3] = 32'hFFFF_FFFF;
        ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110;
        ops[4] = 3'b111; ops[5] = 3'b011; ops[6] = 3'b100; ops[7] = 3'b101;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // reset state: zero operands with AND give zero result, zero flag (R1, R7)
        check("R1", result_o, 32'd0);
        check("R7", {31'd0, zero_o}, 32'd1);

        // overflow-sensitive comparison example (R5)
        drive(32'h8000_0000, 32'h0000_0001, 3'b111);
        drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
        // equal operands on subtract set zero (R7)
        drive(32'h1234_5678, 32'h1234_5678, 3'b110);

        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                for (int k = 0; k < 8; k++)
                    drive(corner[i], corner[j], ops[k]);

        for (int n = 0; n < 400; n++)
            drive($urandom, $urandom, ops[n % 8]);

        @(negedge clk);
        wait (q.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule